// File: doc/BRIEF.md
# Packed BCD String Sequencer

This block runs decimal arithmetic over two packed-BCD strings held in a byte-wide memory. One command starts it. The command gives an operation code, a digit count, a source base address and a destination base address. The sequencer then visits the strings one byte at a time, starting at the lowest address, which holds the least significant digits. Each byte carries two digits, and the decimal carry or borrow passes from digit to digit and from byte to byte.

Add and subtract write the result back over the destination string. Compare computes the same difference as subtract but writes nothing. When the whole string has been processed, the block raises a one-cycle done pulse. At that point a carry/borrow flag and an all-digits-zero flag describe the complete result. The memory port is a simple synchronous one: read data appears on the cycle after a read request, and a write takes effect at the clock edge on which it is requested.

Top module: `bcd_string_unit`

## Requirements
- R1: Operation codes on `op_i` are 0x20 for add, 0x22 for subtract and 0x26 for compare. A start with any other code is ignored: busy stays low and memory is not touched.
- R2: Digit k of a string sits in byte base+k/2, in bits 3:0 when k is even and bits 7:4 when k is odd. The number of bytes processed is ceil(count/2), so an odd count also processes the top nibble of the last byte as an ordinary digit. Bytes past that range are not written. A start with count 0 is ignored.
- R3: Add replaces the destination with the decimal sum destination + source. The carry flag is the decimal carry out of the topmost processed digit.
- R4: Subtract replaces the destination with the decimal difference destination − source, taken modulo 10^digits. The carry flag is set when a borrow leaves the topmost digit.
- R5: Compare writes no memory and sets the carry and zero flags exactly as subtract would.
- R6: The zero flag is set only when every processed result digit is zero, including the pad digit of an odd count.
- R7: A start is accepted when the block is idle, the code is valid and the count is nonzero. Busy is high from the edge that accepts the start until the edge after done. Done is high for exactly one cycle, beginning 3×bytes clock edges after the accepting edge.
- R8: A start request while busy is ignored and does not disturb the operation in progress.
- R9: The carry and zero flags hold their final values after done until the next accepted start.
- R10: While idle, no memory request is issued. A write is always accompanied by a request. Read data is taken from the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request |
| op_i | input | 8 | Operation code |
| count_i | input | CW | Digit count |
| src_addr_i | input | AW | Source string base address |
| dst_addr_i | input | AW | Destination string base address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry (add) or borrow (subtract, compare) |
| zero_o | output | 1 | Whole result is zero |

## Verification
A fault in the digit chain shows up as a wrong byte in the destination. It becomes visible at the write of that byte, 3 cycles into the byte, and it also propagates to later bytes through the carry. The bench's expected memory and flags therefore diverge within one byte period. A fault in the byte counter or the state sequencing moves the done pulse or the busy window. A fault that lets a request escape while idle breaks the per-cycle comparison of busy, done and request on the very next cycle. A flag register that fails to accumulate or fails to clear at start is caught at the done cycle of any string whose earlier bytes disagree with its last byte.

// File: rtl/bcd_str_pkg.sv
package bcd_str_pkg;

  localparam logic [7:0] OPC_ADD = 8'h20;
  localparam logic [7:0] OPC_SUB = 8'h22;
  localparam logic [7:0] OPC_CMP = 8'h26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_EXEC,
    ST_FIN
  } seq_state_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_CMP);
  endfunction

  // {carry_or_borrow, digit}
  function automatic logic [4:0] digit_step(input logic [3:0] a, input logic [3:0] b,
                                            input logic cin, input logic sub);
    logic [4:0] t;
    if (!sub) begin
      t = {1'b0, a} + {1'b0, b} + {4'b0, cin};
      if (t > 5'd9) return {1'b1, t[3:0] + 4'd6};
      return {1'b0, t[3:0]};
    end else begin
      t = {1'b0, a} - {1'b0, b} - {4'b0, cin};
      if (t[4]) return {1'b1, t[3:0] - 4'd6};
      return {1'b0, t[3:0]};
    end
  endfunction

endpackage

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  import bcd_str_pkg::*;

  always_comb begin
    logic       c;
    logic [4:0] step;
    c     = cin_i;
    res_o = '0;
    for (int g = 0; g < DIGITS; g++) begin
      step          = digit_step(dst_i[4*g +: 4], src_i[4*g +: 4], c, sub_i);
      res_o[4*g +: 4] = step[3:0];
      c             = step[4];
    end
    cout_o = c;
  end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [CW-1:0] nbytes_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic          wr_en_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          src_cap_o,
  output logic          exec_o,
  output logic          busy_o,
  output logic          done_o
);
  import bcd_str_pkg::*;

  seq_state_e    state_q;
  logic [CW-1:0] idx_q, nb_q;
  logic [AW-1:0] sbase_q, dbase_q;
  logic          wr_q;
  logic          last_byte;

  assign last_byte = (idx_q == nb_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      nb_q    <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          state_q <= ST_RD_SRC;
          idx_q   <= '0;
          nb_q    <= nbytes_i;
          sbase_q <= src_base_i;
          dbase_q <= dst_base_i;
          wr_q    <= wr_en_i;
        end
        ST_RD_SRC: state_q <= ST_RD_DST;
        ST_RD_DST: state_q <= ST_EXEC;
        ST_EXEC: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= last_byte ? ST_FIN : ST_RD_SRC;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST) ||
                 ((state_q == ST_EXEC) && wr_q);
    mem_we_o   = (state_q == ST_EXEC) && wr_q;
    mem_addr_o = ((state_q == ST_RD_SRC) ? sbase_q : dbase_q) + AW'(idx_q);
  end

  assign src_cap_o = (state_q == ST_RD_DST);
  assign exec_o    = (state_q == ST_EXEC);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);

endmodule

// File: rtl/bcd_string_unit.sv
module bcd_string_unit #(
  parameter int AW     = 16,
  parameter int CW     = 8,
  parameter int DIGITS = 2,
  localparam int DW    = 4 * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    op_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          carry_o,
  output logic          zero_o
);
  import bcd_str_pkg::*;

  logic          accept;
  logic [CW:0]   cnt_rnd;
  logic [CW-1:0] nbytes;
  logic          src_cap, exec;
  logic          sub_q, carry_q, zero_q;
  logic [DW-1:0] src_q, alu_res;
  logic          alu_cout;

  // digits per byte: round count up to whole bytes
  assign cnt_rnd = {1'b0, count_i} + (CW+1)'(DIGITS - 1);
  assign nbytes  = CW'(cnt_rnd / (CW+1)'(DIGITS));
  assign accept  = start_i && !busy_o && op_known(op_i) && (count_i != '0);

  bcd_seq_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (accept),
    .nbytes_i   (nbytes),
    .src_base_i (src_addr_i),
    .dst_base_i (dst_addr_i),
    .wr_en_i    (op_i != OPC_CMP),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .src_cap_o  (src_cap),
    .exec_o     (exec),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  bcd_byte_alu #(.DIGITS(DIGITS)) u_alu (
    .dst_i  (mem_rdata_i),
    .src_i  (src_q),
    .cin_i  (carry_q),
    .sub_i  (sub_q),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      src_q   <= '0;
    end else begin
      if (accept) begin
        sub_q   <= (op_i != OPC_ADD);
        carry_q <= 1'b0;
        zero_q  <= 1'b1;
      end
      if (src_cap) src_q <= mem_rdata_i;
      if (exec) begin
        carry_q <= alu_cout;
        zero_q  <= zero_q && (alu_res == '0);
      end
    end
  end

  assign mem_wdata_o = alu_res;
  assign carry_o     = carry_q;
  assign zero_o      = zero_q;

endmodule

// File: rtl/bcd_string_unit_chk.sv
module bcd_string_unit_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [7:0]    op_i,
  input logic [CW-1:0] count_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          carry_o,
  input logic          zero_o
);
  import bcd_str_pkg::*;

  logic cmp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else if (start_i && !busy_o) cmp_q <= (op_i == OPC_CMP);
  end

  a_r10_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r10_we_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  a_r5_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_q) |-> !mem_we_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r7_busy_by_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r1_bad_op_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !op_known(op_i)) |=> !busy_o);
  a_r2_zero_count_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> !busy_o);
  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!busy_o) && !busy_o) |-> ($stable(carry_o) && $stable(zero_o)));

endmodule

bind bcd_string_unit bcd_string_unit_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_i      (op_i),
  .count_i   (count_i),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o)
);

// File: tb/tb_bcd_string_unit.sv
`timescale 1ns/1ps
module tb_bcd_string_unit;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [7:0]    op = 8'h00;
  logic [CW-1:0] cnt = '0;
  logic [AW-1:0] sa = '0, da = '0;
  logic          mem_req, mem_we, busy, done, carry, zero;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  bcd_string_unit #(.AW(AW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .count_i(cnt),
    .src_addr_i(sa), .dst_addr_i(da), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .carry_o(carry), .zero_o(zero));

  // byte memory with preload path
  logic [7:0] mem [0:255];
  logic       pl_we = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  always @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural timing model
  bit m_busy = 0;
  int m_rem = 0;
  bit exp_c = 0, exp_z = 0;
  string flag_req = "R3";
  function automatic bit cmd_ok(input logic [7:0] o, input logic [CW-1:0] c);
    return (o == 8'h20 || o == 8'h22 || o == 8'h26) && c != 0;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_busy <= 0; m_rem <= 0; end
    else if (m_busy) begin
      if (m_rem == 0) m_busy <= 0; else m_rem <= m_rem - 1;
    end else if (start && cmd_ok(op, cnt)) begin
      m_busy <= 1;
      m_rem  <= 3 * ((int'(cnt) + 1) / 2);
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(busy == m_busy, "R7", "busy", busy, m_busy);
    chk(done == (m_busy && m_rem == 0), "R7", "done", done, m_busy && m_rem == 0);
    if (!m_busy) chk(!mem_req, "R10", "idle request", mem_req, 0);
    if (m_busy && m_rem == 0) begin
      chk(carry == exp_c, flag_req, "carry at done", carry, exp_c);
      chk(zero == exp_z, "R6", "zero at done", zero, exp_z);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); pl_we = 1; pl_addr = 8'(a); pl_data = d;
    @(negedge clk); pl_we = 0;
  endtask

  task automatic set_num(input int base, input int nb, input longint val);
    for (int k = 0; k < nb; k++) begin
      logic [3:0] lo, hi;
      lo = 4'(val % 10); val = val / 10;
      hi = 4'(val % 10); val = val / 10;
      wr(base + k, {hi, lo});
    end
  endtask

  logic [7:0] exp_b [0:127];

  // decimal definition of each operation, digit by digit
  task automatic run_op(input logic [7:0] o, input int c, input int sb, input int db,
                        input string req, input bit poke_busy);
    int nb, carry_i, a, b, v, r;
    logic [7:0] beyond, res;
    nb = (c + 1) / 2;
    carry_i = 0; exp_z = 1;
    for (int k = 0; k < nb; k++) begin
      res = '0;
      for (int j = 0; j < 2; j++) begin
        a = int'(mem[(db + k) % 256][4*j +: 4]);
        b = int'(mem[(sb + k) % 256][4*j +: 4]);
        if (o == 8'h20) begin
          v = a + b + carry_i; carry_i = (v >= 10); r = v % 10;
        end else begin
          v = a - b - carry_i; carry_i = (v < 0); r = (v < 0) ? v + 10 : v;
        end
        if (r != 0) exp_z = 0;
        res[4*j +: 4] = 4'(r);
      end
      exp_b[k] = (o == 8'h26) ? mem[(db + k) % 256] : res;
    end
    exp_c = carry_i[0];
    flag_req = req;
    beyond = mem[(db + nb) % 256];
    @(negedge clk);
    start = 1; op = o; cnt = CW'(c); sa = AW'(sb); da = AW'(db);
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      repeat (2) @(negedge clk);
      start = 1; op = 8'h22; cnt = 8'd4; sa = 16'h00F0; da = 16'h00F8;  // R8
      @(negedge clk);
      start = 0;
    end
    while (m_busy) @(negedge clk);
    for (int k = 0; k < nb; k++)
      chk(mem[(db + k) % 256] == exp_b[k], req, "result byte", mem[(db + k) % 256], exp_b[k]);
    chk(mem[(db + nb) % 256] == beyond, "R2", "byte past string", mem[(db + nb) % 256], beyond);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R10", "reset state",
        {busy, done, mem_req}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) wr(i, 8'h00);

    // R3 plain add
    set_num(8'h10, 2, 1234); set_num(8'h20, 2, 5678);
    run_op(8'h20, 4, 8'h10, 8'h20, "R3", 0);
    // R3 carry out, R6 all-zero result
    set_num(8'h10, 2, 1); set_num(8'h20, 2, 9999);
    run_op(8'h20, 4, 8'h10, 8'h20, "R3", 0);
    // R4 subtract, no borrow
    set_num(8'h10, 2, 1234); set_num(8'h20, 2, 5000);
    run_op(8'h22, 4, 8'h10, 8'h20, "R4", 0);
    // R4 borrow out
    set_num(8'h10, 2, 456); set_num(8'h20, 2, 123);
    run_op(8'h22, 4, 8'h10, 8'h20, "R4", 0);
    // R5 compare equal, then less-than
    set_num(8'h10, 3, 314159); set_num(8'h20, 3, 314159);
    run_op(8'h26, 6, 8'h10, 8'h20, "R5", 0);
    set_num(8'h10, 3, 314160);
    run_op(8'h26, 6, 8'h10, 8'h20, "R5", 0);
    // R2 odd count: pad digit takes the carry
    wr(8'h30, 8'h09); wr(8'h40, 8'h09);
    run_op(8'h20, 1, 8'h30, 8'h40, "R2", 0);
    chk(mem[8'h40] == 8'h18, "R2", "odd count pad digit", mem[8'h40], 8'h18);
    // R8 start while busy ignored
    set_num(8'h10, 2, 4321); set_num(8'h20, 2, 1111);
    run_op(8'h20, 4, 8'h10, 8'h20, "R8", 1);
    // R9 flags hold after done
    begin
      bit c0, z0;
      c0 = carry; z0 = zero;
      repeat (5) @(negedge clk);
      chk(carry == c0 && zero == z0, "R9", "flags held", {carry, zero}, {c0, z0});
    end
    // R1 unknown opcode ignored
    @(negedge clk); start = 1; op = 8'h24; cnt = 8'd4; sa = 16'h0010; da = 16'h0020;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "bad opcode busy", busy, 0);
    chk(mem[8'h20] == 8'h32 && mem[8'h21] == 8'h54, "R1", "bad opcode memory",
        {mem[8'h21], mem[8'h20]}, 16'h5432);
    // R2 zero count ignored
    @(negedge clk); start = 1; op = 8'h20; cnt = 8'd0;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem[8'h20] == 8'h32, "R2", "zero count", {busy, mem[8'h20]}, 8'h32);
    // R3 and R4 long strings, 254 digits
    for (int k = 0; k < 127; k++) begin
      wr(k, {4'((k * 3 + 1) % 10), 4'((k * 7) % 10)});
      wr(128 + k, {4'((k * 5 + 2) % 10), 4'((k * 9) % 10)});
    end
    wr(255, 8'h77);
    run_op(8'h20, 254, 0, 128, "R3", 0);
    run_op(8'h22, 254, 0, 128, "R4", 0);
    run_op(8'h26, 253, 0, 128, "R5", 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule